// File: doc/BRIEF.md
# Credit-Based Latency-Modeling Channel

This block joins two emulated units with a one-way, point-to-point path that carries fixed-width fragments. A fragment accepted from the sending side moves through a delay line of configurable length, then lands in a small receive buffer where the receiving side picks it up. Both ends use a valid/ready handshake.

Flow control is based on credits. The sending side holds a counter that starts at the buffering depth. Each accepted fragment spends one credit. Each fragment taken by the receiver sends one credit back through a delay line of the same length as the data path. Because of this, the time a fragment spends in the channel and the amount of traffic it can hold are two separate parameters. The channel therefore behaves like a timed link in the target system rather than like a plain queue. Elaboration stops with an error if the width, the latency or the depth is set below 1.

Top module: `credit_chan`

## Requirements
- R1: After reset, `snd_ready` is 1 (credits are available) and `rcv_valid` is 0.
- R2: Every accepted fragment is delivered exactly once, in the order it was accepted. None is lost or duplicated.
- R3: A fragment accepted in cycle c (`snd_valid` and `snd_ready` both 1) is first presented on `rcv_valid`/`rcv_data` in cycle c+LATENCY and never earlier. It therefore never reaches the receiver in the cycle it was sent.
- R4: `snd_ready` is 1 only while at least one credit remains. After DEPTH fragments are accepted with no dequeue, `snd_ready` drops to 0. A fragment offered while `snd_ready` is 0 is discarded and never delivered.
- R5: The credit count resets to DEPTH. It drops by one for each accepted fragment and rises by one for each returned credit. When both happen in the same cycle it is left unchanged. As a result, with DEPTH at least 2*LATENCY and a receiver that is always ready, `snd_ready` stays 1 in every cycle of a back-to-back stream.
- R6: The receive buffer holds up to DEPTH fragments and never overflows. While `rcv_valid` is 1 and `rcv_ready` is 0, the presented fragment stays valid and unchanged.
- R7: Suppose the sender has zero credits and the receiver dequeues one fragment in cycle d. Then `snd_ready` stays 0 through cycle d+LATENCY-1 and becomes 1 in cycle d+LATENCY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Sender offers a fragment |
| snd_data | input | WIDTH | Offered fragment |
| snd_ready | output | 1 | A credit is available; the offer is taken at the clock edge |
| rcv_valid | output | 1 | Head fragment is present for the receiver |
| rcv_data | output | WIDTH | Head fragment |
| rcv_ready | input | 1 | Receiver takes the head fragment |

## Verification
The checker assumes two things about the inputs. First, the sender may assert `snd_valid` freely, but only an offer that coincides with `snd_ready` counts as a send. Second, the receiver dequeues only while `rcv_valid` is 1. The overflow and credit-bound properties rely on these assumptions together with the credit loop. The directed scenarios stay within them: senders read `snd_ready` before counting a fragment as sent, and offers made while it is low use a marker value that must never reach the receiver. The receiver's ready line is held low, pulsed for a single cycle, kept high, or toggled in a fixed pattern, so that every dequeue pattern still respects the valid/ready rule.

// File: rtl/cc_pkg.sv
package cc_pkg;
   // bits needed to hold any count 0..n
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // bits needed to index n entries
   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cc_delay_line.sv
module cc_delay_line #(
   parameter int W      = 8,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_wire
         assign d_out = d_in;
      end else begin : g_regs
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cc_rx_fifo.sv
module cc_rx_fifo
   import cc_pkg::*;
#(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = idx_bits(DEPTH),
   localparam int CW   = cnt_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic          not_empty,
   output logic [CW-1:0] level
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en) wp_q <= bump(wp_q);
         if (rd_en) rp_q <= bump(rp_q);
         case ({wr_en, rd_en})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp_q] <= wr_data;
   end

   assign rd_data   = mem[rp_q];
   assign not_empty = (cnt_q != '0);
   assign level     = cnt_q;
endmodule

// File: rtl/cc_credit_ctr.sv
module cc_credit_ctr
   import cc_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW   = cnt_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] avail,
   output logic          has_credit
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CW'(DEPTH);
      end else begin
         case ({take, give})
            2'b10:   cnt_q <= cnt_q - CW'(1);
            2'b01:   cnt_q <= cnt_q + CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign avail      = cnt_q;
   assign has_credit = (cnt_q != '0);
endmodule

// File: rtl/credit_chan.sv
module credit_chan
   import cc_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int LATENCY = 2,
   parameter int DEPTH   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_valid,
   input  logic [WIDTH-1:0] snd_data,
   output logic             snd_ready,
   output logic             rcv_valid,
   output logic [WIDTH-1:0] rcv_data,
   input  logic             rcv_ready
);
   // the receive buffer register supplies the last cycle of delay
   localparam int PIPE = LATENCY - 1;
   localparam int CW   = cnt_bits(DEPTH);

   generate
      if (WIDTH < 1 || LATENCY < 1 || DEPTH < 1) begin : g_bad_param
         $error("credit_chan: WIDTH, LATENCY and DEPTH must each be at least 1");
      end
   endgenerate

   logic             snd_fire, deq;
   logic [WIDTH:0]   fwd_in, fwd_out;
   logic             q_wr;
   logic [WIDTH-1:0] q_wdata;
   logic [CW-1:0]    q_level;
   logic             cred_ret;
   logic [CW-1:0]    credits;

   assign snd_fire = snd_valid && snd_ready;
   assign deq      = rcv_valid && rcv_ready;
   assign fwd_in   = {snd_fire, snd_data};
   assign q_wr     = fwd_out[WIDTH];
   assign q_wdata  = fwd_out[WIDTH-1:0];

   cc_delay_line #(.W(WIDTH + 1), .STAGES(PIPE)) fwd_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (fwd_in),
      .d_out (fwd_out)
   );

   cc_rx_fifo #(.W(WIDTH), .DEPTH(DEPTH)) rxq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (q_wr),
      .wr_data   (q_wdata),
      .rd_en     (deq),
      .rd_data   (rcv_data),
      .not_empty (rcv_valid),
      .level     (q_level)
   );

   cc_delay_line #(.W(1), .STAGES(PIPE)) ret_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (deq),
      .d_out (cred_ret)
   );

   cc_credit_ctr #(.DEPTH(DEPTH)) crd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (snd_fire),
      .give       (cred_ret),
      .avail      (credits),
      .has_credit (snd_ready)
   );
endmodule

// File: rtl/credit_chan_chk.sv
module credit_chan_chk #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   parameter int CW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             snd_valid,
   input logic             snd_ready,
   input logic             rcv_valid,
   input logic             rcv_ready,
   input logic [WIDTH-1:0] rcv_data,
   input logic [CW-1:0]    credits,
   input logic [CW-1:0]    q_level,
   input logic             q_wr,
   input logic             cred_ret
);
   p_credit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CW'(DEPTH));

   p_credit_spend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_ready && !cred_ret) |=> credits == $past(credits) - CW'(1));

   p_credit_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_valid && snd_ready && cred_ret) |=> $stable(credits));

   p_no_send_dry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (credits == '0) |-> !snd_ready);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_wr && !(rcv_valid && rcv_ready)) |-> q_level < CW'(DEPTH));

   p_head_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_valid && !rcv_ready) |=> rcv_valid && $stable(rcv_data));
endmodule

bind credit_chan credit_chan_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .snd_valid (snd_valid),
   .snd_ready (snd_ready),
   .rcv_valid (rcv_valid),
   .rcv_ready (rcv_ready),
   .rcv_data  (rcv_data),
   .credits   (credits),
   .q_level   (q_level),
   .q_wr      (q_wr),
   .cred_ret  (cred_ret)
);

// File: tb/credit_chan_tb_top.sv
`timescale 1ns/1ps
module credit_chan_tb_top;
   localparam int W = 8;
   localparam int L = 2;
   localparam int D = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         snd_valid = 1'b0;
   logic [W-1:0] snd_data = '0;
   logic         snd_ready;
   logic         rcv_valid;
   logic [W-1:0] rcv_data;
   logic         rcv_ready = 1'b0;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit exact = 1'b0;
   bit done = 1'b0;
   logic [W-1:0] exp_q[$];
   int           sent_cyc_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   credit_chan #(.WIDTH(W), .LATENCY(L), .DEPTH(D)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_valid (snd_valid),
      .snd_data  (snd_data),
      .snd_ready (snd_ready),
      .rcv_valid (rcv_valid),
      .rcv_data  (rcv_data),
      .rcv_ready (rcv_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, expv);
      end
   endtask

   // scoreboard: sampled at the falling edge, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (snd_valid && snd_ready) begin
            exp_q.push_back(snd_data);
            sent_cyc_q.push_back(cyc);
         end
         if (rcv_valid && rcv_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 (extra fragment)", int'(rcv_data), -1);
            end else begin
               logic [W-1:0] e;
               int sc;
               e  = exp_q.pop_front();
               sc = sent_cyc_q.pop_front();
               chk(rcv_data == e, "R2 (order)", int'(rcv_data), int'(e));
               if (exact) chk(cyc == sc + L, "R3 (arrival cycle)", cyc, sc + L);
            end
         end
      end
   end

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(snd_ready == 1'b1, "R1 snd_ready", int'(snd_ready), 1);
      chk(rcv_valid == 1'b0, "R1 rcv_valid", int'(rcv_valid), 0);
   endtask

   task automatic t_latency();
      int n;
      exact = 1'b1;
      @(posedge clk); #1;
      rcv_ready = 1'b1;
      snd_valid = 1'b1;
      snd_data  = 8'h5A;
      n = cyc;
      for (int k = 0; k <= L; k++) begin
         @(negedge clk);
         if (k == 0) begin
            @(posedge clk); #1 snd_valid = 1'b0;
         end
      end
      // reached cycle n+L: rerun with explicit per-cycle checks on a new fragment
      repeat (2) @(posedge clk);
      #1;
      snd_valid = 1'b1;
      snd_data  = 8'hC3;
      n = cyc;
      for (int k = 0; k <= L; k++) begin
         @(negedge clk);
         chk(rcv_valid == (k == L), "R3 visibility", int'(rcv_valid), int'(k == L));
         if (k == L) chk(rcv_data == 8'hC3, "R3 data", int'(rcv_data), 8'hC3);
         if (k == 0) begin
            @(posedge clk); #1 snd_valid = 1'b0;
         end
      end
      repeat (3) @(negedge clk);
      exact = 1'b0;
   endtask

   task automatic t_backpressure_and_return();
      int accepted = 0;
      int d, s;
      @(posedge clk); #1 rcv_ready = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (i > 0) begin
            @(posedge clk); #1;
         end
         snd_valid = 1'b1;
         snd_data  = snd_ready ? W'(8'h10 + accepted) : 8'hEE;
         @(negedge clk);
         if (snd_valid && snd_ready) accepted++;
      end
      @(posedge clk); #1 snd_valid = 1'b0;
      @(negedge clk);
      chk(accepted == D, "R4 accepted count", accepted, D);
      chk(snd_ready == 1'b0, "R4 credits exhausted", int'(snd_ready), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(rcv_valid && rcv_data == 8'h10, "R6 head held", int'(rcv_data), 8'h10);
      end
      // single dequeue, then watch the credit come back
      @(posedge clk); #1 rcv_ready = 1'b1;
      d = cyc;
      for (int k = 0; k <= L; k++) begin
         @(negedge clk);
         chk(snd_ready == (k == L), "R7 credit return timing", int'(snd_ready), int'(k == L));
         if (k == 1) chk(rcv_data == 8'h11, "R2 next head", int'(rcv_data), 8'h11);
         if (k == 0) begin
            @(posedge clk); #1 rcv_ready = 1'b0;
         end
      end
      chk(cyc == d + L, "R7 cycle index", cyc, d + L);
      @(posedge clk); #1;
      snd_valid = 1'b1;
      snd_data  = 8'h14;
      s = cyc;
      @(posedge clk); #1 snd_valid = 1'b0;
      @(negedge clk);
      chk(snd_ready == 1'b0, "R5 spend last credit", int'(snd_ready), 0);
      chk(cyc == s + 1, "R5 cycle index", cyc, s + 1);
      @(posedge clk); #1 rcv_ready = 1'b1;
      repeat (16) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);
      chk(snd_ready == 1'b1, "R5 credits restored", int'(snd_ready), 1);
      @(posedge clk); #1 rcv_ready = 1'b0;
   endtask

   task automatic t_stream();
      int low = 0;
      exact = 1'b1;
      @(posedge clk); #1 rcv_ready = 1'b1;
      for (int i = 0; i < 24; i++) begin
         if (i > 0) begin
            @(posedge clk); #1;
         end
         snd_valid = 1'b1;
         snd_data  = W'(i * 7 + 3);
         @(negedge clk);
         if (!snd_ready) low++;
      end
      @(posedge clk); #1 snd_valid = 1'b0;
      chk(low == 0, "R5 full-rate stream", low, 0);
      repeat (L + 4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 stream delivered", exp_q.size(), 0);
      exact = 1'b0;
   endtask

   task automatic t_toggle();
      int next = 0;
      for (int it = 0; it < 300 && next < 30; it++) begin
         @(posedge clk); #1;
         rcv_ready = (cyc % 3) != 1;
         snd_valid = 1'b1;
         snd_data  = snd_ready ? W'(8'h80 + next) : 8'hEE;
         @(negedge clk);
         if (snd_valid && snd_ready) next++;
      end
      @(posedge clk); #1;
      snd_valid = 1'b0;
      rcv_ready = 1'b1;
      repeat (20) @(negedge clk);
      chk(next == 30, "R4 toggle sends", next, 30);
      chk(exp_q.size() == 0, "R2 toggle delivered", exp_q.size(), 0);
      chk(rcv_valid == 1'b0, "R6 drained", int'(rcv_valid), 0);
   endtask

   initial begin
      t_reset();
      t_latency();
      t_backpressure_and_return();
      t_stream();
      t_toggle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1..: run hung actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule